// File: doc/BRIEF.md
# Widest Free-Band Run Detector

This block watches a stream of spectrum power bins, one bin word per clock, and finds the widest stretch of adjacent quiet bins in each frame. A bin is quiet (low power) when its word is below a threshold supplied on a separate input. At the last bin of a frame, the block reports the index of the first bin of the longest quiet stretch and its length in bins. The report is latched into a result register together with a one-cycle start pulse for a downstream result sender.

The bin stream passes through to the output stream by wires only. Ready travels back from the output to the input, so any stall comes from downstream alone and the block adds no latency. Internally, two run trackers are kept and the smaller one is recycled whenever a new quiet run begins. The final bin of a frame is folded into the comparison in the same cycle that the result is latched.

Top module: `free_band_finder`

## Requirements
- R1: `m_data`, `m_valid` and `m_last` equal `s_data`, `s_valid` and `s_last` in the same cycle, and `s_ready` equals `m_ready`.
- R2: A bin is consumed only on a cycle with `s_valid` and `m_ready` both high. The bin index advances only on such cycles. Data presented with either signal low has no effect on the result.
- R3: A bin is low power when `s_data < thresh` compared as unsigned 32-bit values. A bin equal to or above the threshold is high power.
- R4: A quiet run that begins loads whichever of the two trackers has the smaller size (tracker 1 on a tie) with start = current bin index and size = 1. Further quiet bins add one to that tracker. The first high-power bin ends the run.
- R5: On the beat carrying `s_last`, that bin is included first. The tracker with the larger size is then copied to `res_start`/`res_size`, with tracker 1 chosen on equal sizes. The new values are visible from the cycle after that beat.
- R6: `res_send` is high for exactly the one cycle after each consumed `s_last` beat, and low otherwise.
- R7: `res_start` and `res_size` hold their values between frame ends.
- R8: After a consumed `s_last` beat, both trackers and the bin index are zero, so each frame is judged on its own bins.
- R9: A frame with no quiet bin reports start 0 and size 0. A full frame of `FRAME_LEN` (1024) quiet bins reports start 0 and size 1024.
- R10: While `rst_n` is low at a clock edge, the result is cleared to start 0, size 0 and `res_send` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thresh | input | 32 | Power threshold, held stable during a frame |
| s_data | input | 32 | Input bin power word |
| s_valid | input | 1 | Input word valid |
| s_last | input | 1 | Input word is the last bin of its frame |
| s_ready | output | 1 | Input ready, copied from `m_ready` |
| m_data | output | 32 | Output bin word |
| m_valid | output | 1 | Output valid |
| m_last | output | 1 | Output last |
| m_ready | input | 1 | Downstream ready |
| res_start | output | 10 | Index of the first bin of the widest quiet run |
| res_size | output | 11 | Length of that run in bins |
| res_send | output | 1 | One-cycle pulse that starts the result sender |

## Verification
The assertions assume that frames never run past `FRAME_LEN` beats without `s_last`, that `thresh` is steady across a frame, and that inputs settle well away from the rising edge. The bench drives its inputs on the falling edge. Every frame it sends is at most 1024 bins long and ends with `s_last`, and it changes the threshold only between frames while the input is idle. It gaps `s_valid` and drops `m_ready` at random, and it puts random data on the bus while no beat is taken, so that both the qualified-beat rule and the assertions are exercised.

// File: rtl/fbf_pkg.sv
// Shared types for the widest free-band run detector.
// Assumes two run trackers, so the scan state names one of them or neither.
package fbf_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_FILL_A = 2'd1,
        ST_FILL_B = 2'd2
    } scan_state_e;

    localparam int NUM_RUNS = 2;

endpackage

// File: rtl/fbf_bin_compare.sv
// Classifies one bin word as low power (strictly below the threshold).
// Assumes both operands are unsigned; equality counts as high power.
module fbf_bin_compare #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] bin,
    input  logic [DATA_W-1:0] limit,
    output logic              is_low
);

    // Unsigned strict comparison against the threshold.
    always_comb begin
        is_low = (bin < limit);
    end

endmodule

// File: rtl/fbf_run_ctrl.sv
// Scan controller: tracks which tracker is filling and the bin index.
// Issues fire-qualified load/increment strobes and a frame-end clear.
// Assumes frames never exceed FRAME_LEN beats.
module fbf_run_ctrl
    import fbf_pkg::*;
#(
    parameter int FRAME_LEN = 1024,
    localparam int IDX_W  = $clog2(FRAME_LEN),
    localparam int SIZE_W = $clog2(FRAME_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  logic                last,
    input  logic                low,
    input  logic [SIZE_W-1:0]   size_a,
    input  logic [SIZE_W-1:0]   size_b,
    output logic [NUM_RUNS-1:0] load,
    output logic [NUM_RUNS-1:0] inc,
    output logic                clear,
    output logic [IDX_W-1:0]    idx_q,
    output scan_state_e         state_q
);

    scan_state_e state_d;
    logic        pick_a;

    // Tracker to recycle: the smaller one, tracker 1 on a tie.
    always_comb begin
        pick_a = (size_a <= size_b);
    end

    // Next state and tracker strobes for the current beat.
    always_comb begin
        load    = '0;
        inc     = '0;
        state_d = state_q;
        if (fire) begin
            if (low) begin
                unique case (state_q)
                    ST_SEARCH: begin
                        if (pick_a) begin
                            load[0] = 1'b1;
                            state_d = ST_FILL_A;
                        end else begin
                            load[1] = 1'b1;
                            state_d = ST_FILL_B;
                        end
                    end
                    ST_FILL_A: inc[0] = 1'b1;
                    ST_FILL_B: inc[1] = 1'b1;
                    default:   state_d = ST_SEARCH;
                endcase
            end else begin
                state_d = ST_SEARCH;
            end
            if (last) begin
                state_d = ST_SEARCH;
            end
        end
    end

    // Frame-end clear strobe.
    always_comb begin
        clear = fire && last;
    end

    // State register, returned to search on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Bin index: advances per consumed beat, zeroed at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (fire) begin
            idx_q <= last ? '0 : idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/fbf_run_slot.sv
// One run tracker: a start index and a run size.
// Exposes its next value so the frame-end bin can be folded in the same cycle.
// Assumes load and inc are never high together.
module fbf_run_slot #(
    parameter int FRAME_LEN = 1024,
    localparam int IDX_W  = $clog2(FRAME_LEN),
    localparam int SIZE_W = $clog2(FRAME_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              inc,
    input  logic              clear,
    input  logic [IDX_W-1:0]  idx,
    output logic [SIZE_W-1:0] cur_size,
    output logic [IDX_W-1:0]  nxt_start,
    output logic [SIZE_W-1:0] nxt_size
);

    logic [IDX_W-1:0] cur_start;

    // Value after this beat: new run, extended run or unchanged.
    always_comb begin
        nxt_start = cur_start;
        nxt_size  = cur_size;
        if (load) begin
            nxt_start = idx;
            nxt_size  = SIZE_W'(1);
        end else if (inc) begin
            nxt_size  = cur_size + 1'b1;
        end
    end

    // Tracker storage, emptied at frame end and on reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cur_start <= '0;
            cur_size  <= '0;
        end else begin
            cur_start <= nxt_start;
            cur_size  <= nxt_size;
        end
    end

endmodule

// File: rtl/fbf_result_reg.sv
// Picks the larger tracker at frame end and holds it for the result sender.
// Assumes take is high only on the consumed frame-end beat.
module fbf_result_reg #(
    parameter int FRAME_LEN = 1024,
    localparam int IDX_W  = $clog2(FRAME_LEN),
    localparam int SIZE_W = $clog2(FRAME_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [IDX_W-1:0]  start_a,
    input  logic [SIZE_W-1:0] size_a,
    input  logic [IDX_W-1:0]  start_b,
    input  logic [SIZE_W-1:0] size_b,
    output logic [IDX_W-1:0]  res_start,
    output logic [SIZE_W-1:0] res_size,
    output logic              res_send
);

    logic              use_b;
    logic [IDX_W-1:0]  win_start;
    logic [SIZE_W-1:0] win_size;

    // Larger run wins, tracker 1 on equal sizes.
    always_comb begin
        use_b     = (size_b > size_a);
        win_start = use_b ? start_b : start_a;
        win_size  = use_b ? size_b  : size_a;
    end

    // Send register, loaded only at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_start <= '0;
            res_size  <= '0;
        end else if (take) begin
            res_start <= win_start;
            res_size  <= win_size;
        end
    end

    // One-cycle start pulse for the sender.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_send <= 1'b0;
        end else begin
            res_send <= take;
        end
    end

endmodule

// File: rtl/free_band_finder.sv
// Widest free-band run detector: streams bins through unchanged and reports
// the longest run of bins below the threshold at each frame end.
// Assumes thresh is stable across a frame and frames end with s_last.
module free_band_finder
    import fbf_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int FRAME_LEN = 1024,
    localparam int IDX_W  = $clog2(FRAME_LEN),
    localparam int SIZE_W = $clog2(FRAME_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] thresh,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    output logic              m_last,
    input  logic              m_ready,
    output logic [IDX_W-1:0]  res_start,
    output logic [SIZE_W-1:0] res_size,
    output logic              res_send
);

    logic                fire;
    logic                low;
    logic                clear;
    logic [NUM_RUNS-1:0] load;
    logic [NUM_RUNS-1:0] inc;
    logic [IDX_W-1:0]    idx_q;
    scan_state_e         state_q;
    logic [SIZE_W-1:0]   cur_size  [NUM_RUNS];
    logic [IDX_W-1:0]    nxt_start [NUM_RUNS];
    logic [SIZE_W-1:0]   nxt_size  [NUM_RUNS];

    // Wire-only pass-through of the bin stream.
    always_comb begin
        m_data  = s_data;
        m_valid = s_valid;
        m_last  = s_last;
        s_ready = m_ready;
        fire    = s_valid && m_ready;
    end

    fbf_bin_compare #(.DATA_W(DATA_W)) u_cmp (
        .bin    (s_data),
        .limit  (thresh),
        .is_low (low)
    );

    fbf_run_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .last    (s_last),
        .low     (low),
        .size_a  (cur_size[0]),
        .size_b  (cur_size[1]),
        .load    (load),
        .inc     (inc),
        .clear   (clear),
        .idx_q   (idx_q),
        .state_q (state_q)
    );

    for (genvar g = 0; g < NUM_RUNS; g++) begin : g_slot
        fbf_run_slot #(.FRAME_LEN(FRAME_LEN)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load[g]),
            .inc       (inc[g]),
            .clear     (clear),
            .idx       (idx_q),
            .cur_size  (cur_size[g]),
            .nxt_start (nxt_start[g]),
            .nxt_size  (nxt_size[g])
        );
    end

    fbf_result_reg #(.FRAME_LEN(FRAME_LEN)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (clear),
        .start_a   (nxt_start[0]),
        .size_a    (nxt_size[0]),
        .start_b   (nxt_start[1]),
        .size_b    (nxt_size[1]),
        .res_start (res_start),
        .res_size  (res_size),
        .res_send  (res_send)
    );

endmodule

// File: rtl/fbf_checker.sv
// Property checker for free_band_finder, attached by bind.
// Assumes synchronous active-low reset and frames no longer than FRAME_LEN.
module fbf_checker
    import fbf_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int FRAME_LEN = 1024,
    localparam int IDX_W  = $clog2(FRAME_LEN),
    localparam int SIZE_W = $clog2(FRAME_LEN + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] thresh,
    input logic [DATA_W-1:0] s_data,
    input logic              s_valid,
    input logic              s_last,
    input logic              m_ready,
    input logic [IDX_W-1:0]  res_start,
    input logic [SIZE_W-1:0] res_size,
    input logic              res_send,
    input logic [IDX_W-1:0]  idx_q,
    input scan_state_e       state_q
);

    logic beat;
    logic beat_end;

    // Beat qualifiers seen from the ports.
    always_comb begin
        beat     = s_valid && m_ready;
        beat_end = beat && s_last;
    end

    // R6: pulse follows every frame end
    p_send_after_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_end |=> res_send);

    // R6: no pulse without a frame end
    p_no_spurious_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_end |=> !res_send);

    // R7: result stable between frame ends
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_end |=> ($stable(res_start) && $stable(res_size)));

    // R8: index zero after a frame end
    p_index_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        beat_end |=> (idx_q == '0));

    // R4: a high-power bin returns the scan to search
    p_high_ends_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !(s_data < thresh)) |=> (state_q == ST_SEARCH));

    // R2: idle cycles leave the index untouched
    p_idle_no_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !beat |=> $stable(idx_q));

    // R5: reported run fits within the bins seen so far
    p_size_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_end |=> (32'(res_size) <= 32'($past(idx_q)) + 32'd1));

    // R9: size never exceeds a frame
    p_size_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(res_size) <= FRAME_LEN);

endmodule

bind free_band_finder fbf_checker #(
    .DATA_W    (DATA_W),
    .FRAME_LEN (FRAME_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .thresh    (thresh),
    .s_data    (s_data),
    .s_valid   (s_valid),
    .s_last    (s_last),
    .m_ready   (m_ready),
    .res_start (res_start),
    .res_size  (res_size),
    .res_send  (res_send),
    .idx_q     (idx_q),
    .state_q   (state_q)
);

// File: tb/sim_free_band_finder.sv
// Bench for free_band_finder: behavioural per-cycle reference plus directed frames.
module sim_free_band_finder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] thresh = 32'd1000;
    logic [31:0] s_data = '0;
    logic        s_valid = 1'b0;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic [31:0] m_data;
    logic        m_valid;
    logic        m_last;
    logic        m_ready = 1'b0;
    logic [9:0]  res_start;
    logic [10:0] res_size;
    logic        res_send;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    // Reference model state
    int r_pos [2];
    int r_len [2];
    int m_fill = -1;
    int m_idx = 0;
    int e_start = 0;
    int e_size = 0;
    bit e_send = 1'b0;

    logic [31:0] frame_q [$];

    always #5 clk = ~clk;

    free_band_finder u0 (
        .clk(clk), .rst_n(rst_n), .thresh(thresh),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .m_data(m_data), .m_valid(m_valid), .m_last(m_last), .m_ready(m_ready),
        .res_start(res_start), .res_size(res_size), .res_send(res_send)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
        end
    endtask

    // Behavioural model: longest quiet run via two recycled slots.
    always @(posedge clk) begin
        if (!rst_n) begin
            r_pos = '{0, 0}; r_len = '{0, 0};
            m_fill = -1; m_idx = 0;
            e_start = 0; e_size = 0; e_send = 1'b0;
        end else begin
            e_send = 1'b0;
            if (s_valid && m_ready) begin
                if (s_data < thresh) begin
                    if (m_fill < 0) begin
                        int k;
                        k = (r_len[0] <= r_len[1]) ? 0 : 1;
                        r_pos[k] = m_idx; r_len[k] = 1; m_fill = k;
                    end else begin
                        r_len[m_fill] += 1;
                    end
                end else begin
                    m_fill = -1;
                end
                if (s_last) begin
                    int w;
                    w = (r_len[1] > r_len[0]) ? 1 : 0;
                    e_start = r_pos[w]; e_size = r_len[w]; e_send = 1'b1;
                    r_pos = '{0, 0}; r_len = '{0, 0};
                    m_fill = -1; m_idx = 0;
                end else begin
                    m_idx += 1;
                end
            end
        end
    end

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            check(res_send == e_send, "R6 res_send vs model", int'(res_send), int'(e_send));
            check(int'(res_start) == e_start, "R5 R7 res_start vs model", int'(res_start), e_start);
            check(int'(res_size) == e_size, "R5 R7 res_size vs model", int'(res_size), e_size);
        end
    end

    function automatic logic [31:0] low_word();
        return (thresh == 0) ? 32'd0 : ($urandom % thresh);
    endfunction

    function automatic logic [31:0] high_word();
        logic [31:0] v;
        v = $urandom;
        return (v < thresh) ? thresh : v;
    endfunction

    // Drive frame_q with random gaps in valid and stalls in ready.
    task automatic drive(input int vpct, input int rpct);
        int i = 0;
        int n = frame_q.size();
        while (i < n) begin
            @(negedge clk);
            s_valid = ($urandom_range(0, 99) < vpct);
            m_ready = ($urandom_range(0, 99) < rpct);
            s_data  = s_valid ? frame_q[i] : $urandom;
            s_last  = s_valid ? (i == n - 1) : $urandom_range(0, 1);
            #1;
            check(m_data == s_data, "R1 m_data", int'(m_data), int'(s_data));
            check(m_valid == s_valid && m_last == s_last, "R1 m_valid/m_last",
                  int'({m_valid, m_last}), int'({s_valid, s_last}));
            check(s_ready == m_ready, "R1 s_ready", int'(s_ready), int'(m_ready));
            @(posedge clk);
            if (s_valid && m_ready) i++;
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
        s_data  = $urandom;
        frame_q.delete();
    endtask

    // Build a frame from letters: L low, H high, E equal, Z zero, M all ones.
    task automatic frame_str(input string p, input int vpct, input int rpct);
        for (int i = 0; i < p.len(); i++) begin
            case (p[i])
                "L": frame_q.push_back(low_word());
                "E": frame_q.push_back(thresh);
                "Z": frame_q.push_back(32'd0);
                "M": frame_q.push_back(32'hFFFF_FFFF);
                default: frame_q.push_back(high_word());
            endcase
        end
        drive(vpct, rpct);
    endtask

    // Called right after drive: result cycle is the current one.
    task automatic expect_res(input string tag, input int st, input int sz);
        check(res_send == 1'b1, {tag, " send pulse"}, int'(res_send), 1);
        check(int'(res_start) == st, {tag, " start"}, int'(res_start), st);
        check(int'(res_size) == sz, {tag, " size"}, int'(res_size), sz);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(res_send == 1'b0, "R10 reset res_send", int'(res_send), 0);
        check(res_start == '0, "R10 reset res_start", int'(res_start), 0);
        check(res_size == '0, "R10 reset res_size", int'(res_size), 0);
        rst_n = 1'b1;
        chk_on = 1'b1;
        @(negedge clk);

        // R4: three runs, the middle one longest
        frame_str("HHLLLHLLLLLHLLH", 100, 100);
        expect_res("R4 recycle", 6, 5);
        repeat (2) @(negedge clk);
        // R7: held after the pulse
        check(res_size == 11'd5 && res_send == 1'b0, "R7 hold size", int'(res_size), 5);

        // R2: same frame with valid gaps and ready stalls
        frame_str("HHLLLHLLLLLHLLH", 60, 60);
        expect_res("R2 stalled", 6, 5);

        // R5: last bin extends the winning run
        frame_str("HLLHLLL", 100, 100);
        expect_res("R5 last extends", 4, 3);
        // R5: last bin starts a new run
        frame_str("HHL", 100, 100);
        expect_res("R5 last new run", 2, 1);
        // R4 R5: equal sizes, tracker 1 recycled, tracker 1 wins ties
        frame_str("LLLHLLLHLLLHL", 100, 100);
        expect_res("R4 R5 tie", 4, 3);
        // R8: stale trackers must not leak in
        frame_str("HLH", 100, 100);
        expect_res("R8 fresh frame", 1, 1);

        // R3 R9: bins equal to the threshold are high
        frame_str("EEEE", 100, 100);
        expect_res("R3 R9 equal high", 0, 0);
        // R3: unsigned compare with top bit set
        thresh = 32'h8000_0000;
        @(negedge clk);
        frame_str("MLZELZ", 100, 100);
        expect_res("R3 unsigned", 1, 2);
        thresh = 32'd1000;
        @(negedge clk);

        // R6: single-bin frames
        frame_str("L", 100, 100);
        expect_res("R6 one low", 0, 1);
        frame_str("H", 100, 100);
        expect_res("R6 one high", 0, 0);

        // R9: full frame of quiet bins
        for (int i = 0; i < 1024; i++) frame_q.push_back(low_word());
        drive(100, 100);
        expect_res("R9 full quiet", 0, 1024);

        // R2 R4 R5: random frames against the model
        for (int f = 0; f < 40; f++) begin
            int n = $urandom_range(1, 200);
            int lp = $urandom_range(20, 90);
            thresh = $urandom_range(1, 32'h7FFF_FFFF);
            @(negedge clk);
            for (int i = 0; i < n; i++)
                frame_q.push_back(($urandom_range(0, 99) < lp) ? low_word() :
                                  (($urandom_range(0, 9) == 0) ? thresh : high_word()));
            drive($urandom_range(50, 100), $urandom_range(50, 100));
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule